// File: doc/BRIEF.md
# I2S Stereo Microphone Receiver (Clock Master)

This block is the clock-owning end of an I2S link that serves two microphones sharing one serial data wire. It divides the system clock into a serial bit clock and a word-select signal, always with 64 bit clocks per stereo frame. Each microphone drives the shared wire only during its own 32-bit slot.

During each slot the block samples the wire on the rising edge of the bit clock. It collects a 24-bit two's complement word, MSB first, that begins one bit time after the word-select change. The remaining bit times of the slot are treated as an idle line and ignored. Once the right word of a frame has been collected, the left and right words are presented together in an output register, and a single-cycle valid strobe marks them.

Top module: `i2s_stereo_rx`

## Requirements
- R1: One bit clock period (`sck_o`) is `CLK_DIV` system clock cycles, where `CLK_DIV` is at least 2. The bit clock is low for floor(`CLK_DIV`/2) cycles and high for the rest of the period.
- R2: `ws_o` changes only in the system cycle where `sck_o` falls. A frame is 64 bit clocks: `ws_o` is 0 (left slot) for 32 of them and 1 (right slot) for the next 32.
- R3: While `rst_ni` is low, `sck_o`, `ws_o` and `valid_o` are 0 and both data outputs are zero. The first bit clock period after reset is slot position 0 of the left slot.
- R4: `sd_i` is sampled in the cycle where `sck_o` rises, at slot positions 1 to 24. Position 0 is the bit time in which `ws_o` changed. The bit sampled at position p is data bit 24-p, so the MSB comes first. The word is delivered bit-exact as two's complement.
- R5: Bits on `sd_i` at slot positions 0 and 25 to 31 have no effect on any output.
- R6: `valid_o` is high for exactly one system cycle per frame: the first cycle in which `sck_o` is high at right-slot position 24. In that same cycle, `left_o` and `right_o` show that frame's words. At all other times both outputs hold their values.
- R7: The first `valid_o` after reset carries the first frame after reset, and no strobe comes earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_i | input | 1 | Shared serial data line from the microphones |
| sck_o | output | 1 | Generated bit clock |
| ws_o | output | 1 | Word select: 0 for the left slot, 1 for the right slot |
| left_o | output | WORD_W | Left word of the latest frame |
| right_o | output | WORD_W | Right word of the latest frame |
| valid_o | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
The hardest case to provoke is a driven line during the eight ignored bit times. In that case a receiver that samples one position early or late still looks correct if the idle bits happen to match. The bench drives those ignored positions with an alternating pattern of ones and zeros that changes from frame to frame, so any off-by-one slot window corrupts a word. Extreme words (full-scale negative, full-scale positive, all ones, zero, alternating bits) pin down the bit order. An odd division ratio makes the unequal low and high phases of the bit clock visible.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  localparam int SLOT_BITS  = 32;
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int SLOT_POS_W = $clog2(SLOT_BITS);

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/i2s_sck_gen.sv
module i2s_sck_gen
  import i2s_rx_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             sck_o,
  output logic             rise_o,
  output logic [POS_W-1:0] pos_o
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [CNT_W-1:0] div_q;
  logic             sck_q;
  logic [POS_W-1:0] pos_q;
  logic             at_rise, at_fall;

  assign at_rise = (div_q == CNT_W'(HALF - 1));
  assign at_fall = (div_q == CNT_W'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sck_q <= 1'b0;
      pos_q <= '0;
    end else if (at_fall) begin
      div_q <= '0;
      sck_q <= 1'b0;
      pos_q <= pos_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
      if (at_rise) sck_q <= 1'b1;
    end
  end

  assign sck_o  = sck_q;
  assign rise_o = at_rise;
  assign pos_o  = pos_q;

  assert_pos_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pos_q) |-> $fell(sck_q));
  assert_sck_rise_once_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_q) |=> sck_q || (CLK_DIV - HALF == 1));
endmodule

// File: rtl/i2s_slot_capture.sv
module i2s_slot_capture
  import i2s_rx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              sd_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  logic [SLOT_POS_W-1:0] slot_pos;
  chan_e                 chan;
  logic                  take, last;
  logic [WORD_W-1:0]     shift_q, word_nx, left_hold_q, left_q, right_q;
  logic                  valid_q;

  assign slot_pos = pos_i[SLOT_POS_W-1:0];
  assign chan     = chan_e'(pos_i[POS_W-1]);
  // data window: one bit time after the slot boundary, WORD_W bits long
  assign take     = rise_i && (slot_pos != '0) && (slot_pos <= SLOT_POS_W'(WORD_W));
  assign last     = rise_i && (slot_pos == SLOT_POS_W'(WORD_W));
  assign word_nx  = {shift_q[WORD_W-2:0], sd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q     <= '0;
      left_hold_q <= '0;
      left_q      <= '0;
      right_q     <= '0;
      valid_q     <= 1'b0;
    end else begin
      if (take) shift_q <= word_nx;
      if (last && chan == CH_LEFT) left_hold_q <= word_nx;
      valid_q <= last && (chan == CH_RIGHT);
      if (last && chan == CH_RIGHT) begin
        left_q  <= left_hold_q;
        right_q <= word_nx;
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

  assert_valid_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  assert_valid_in_right_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> pos_i[POS_W-1]);
  assert_left_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(left_q) |-> valid_q);
  assert_right_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(right_q) |-> valid_q);
endmodule

// File: rtl/i2s_stereo_rx.sv
module i2s_stereo_rx
  import i2s_rx_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int WORD_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sd_i,
  output logic              sck_o,
  output logic              ws_o,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  logic             rise;
  logic [POS_W-1:0] pos;

  i2s_sck_gen #(.CLK_DIV(CLK_DIV)) i_sck_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_o  (sck_o),
    .rise_o (rise),
    .pos_o  (pos)
  );

  i2s_slot_capture #(.WORD_W(WORD_W)) i_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .pos_i   (pos),
    .sd_i    (sd_i),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o)
  );

  assign ws_o = pos[POS_W-1];

  assert_ws_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_o) |-> $fell(sck_o));
  assert_valid_sck_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(sck_o));
endmodule

// File: tb/test_i2s_stereo_rx.sv
module test_i2s_stereo_rx;
  localparam int DIV = 3;
  localparam int WW  = 24;
  localparam int NF  = 12;
  localparam int LO_LEN = DIV / 2;
  localparam int HI_LEN = DIV - DIV / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sd = 1'b0;
  logic sck, ws, valid;
  logic [WW-1:0] left, right;

  int n_chk = 0, n_fail = 0;
  int tb_pos = 0, tx_frame = 0, rx_frame = 0;
  bit done = 1'b0;

  i2s_stereo_rx #(.CLK_DIV(DIV), .WORD_W(WW)) i_i2s_stereo_rx (
    .clk_i(clk), .rst_ni(rst_n), .sd_i(sd), .sck_o(sck), .ws_o(ws),
    .left_o(left), .right_o(right), .valid_o(valid)
  );

  always #2.5 clk = ~clk;

  function automatic logic [WW-1:0] word_of(int k, int ch);
    case (k)
      0: return ch ? 24'h7FFFFF : 24'h800000;
      1: return ch ? 24'h000000 : 24'hFFFFFF;
      2: return ch ? 24'hAAAAAA : 24'h555555;
      3: return ch ? 24'h000001 : 24'hFFFFFE;
      default: return WW'(k * 32'h3A7C91 + ch * 32'h9E15B3 + 32'h2468);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic line_bit(int pos, int k);
    int p = pos % 32;
    int ch = pos / 32;
    if (p >= 1 && p <= WW) return word_of(k, ch)[WW - p];
    return logic'((k + p) % 2);  // R5: driven junk in ignored bit times
  endfunction

  // transmitter model: both microphones, driven off the falling bit clock
  initial begin
    @(posedge rst_n);
    sd = line_bit(0, 0);
    forever begin
      @(negedge sck);
      tb_pos = (tb_pos + 1) % 64;
      if (tb_pos == 0) tx_frame++;
      sd = line_bit(tb_pos, tx_frame);
    end
  end

  // monitor
  initial begin
    logic prev_sck = 1'b0, prev_valid = 1'b0;
    int run_len = 0;
    bit seen_rise = 1'b0;
    logic [WW-1:0] exp_l = '0, exp_r = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      chk(ws == (tb_pos >= 32), "R2 ws slot", 32'(ws), 32'(tb_pos >= 32));
      if (sck != prev_sck) begin
        if (seen_rise)
          chk(run_len == (prev_sck ? HI_LEN : LO_LEN), "R1 sck phase length", run_len, prev_sck ? HI_LEN : LO_LEN);
        if (sck) seen_rise = 1'b1;
        run_len = 1;
      end else run_len++;
      prev_sck = sck;
      if (valid) begin
        chk(!prev_valid, "R6 single pulse", 32'(prev_valid), 0);
        chk(tb_pos == 56 && sck, "R6 strobe position", tb_pos, 56);
        if (rx_frame == 0) chk(tx_frame == 0, "R7 first strobe frame", tx_frame, 0);
        exp_l = word_of(rx_frame, 0);
        exp_r = word_of(rx_frame, 1);
        chk(left == exp_l, "R4 R5 left word", left, exp_l);
        chk(right == exp_r, "R4 R5 right word", right, exp_r);
        rx_frame++;
      end else begin
        chk(left == exp_l && right == exp_r, "R6 hold", {8'h0, left}, {8'h0, exp_l});
      end
      prev_valid = valid;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!sck && !ws && !valid, "R3 reset controls", {sck, ws, valid}, 0);
    chk(left == '0 && right == '0, "R3 reset data", {8'h0, left | right}, 0);
    rst_n = 1'b1;
    wait (rx_frame == NF);
    repeat (DIV * 10) @(posedge clk);
    chk(rx_frame == NF, "R6 strobe count", rx_frame, NF);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", rx_frame, NF);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule